// File: doc/BRIEF.md
# Half-Resolution Raster Timing Generator

This block produces the scan timing for an 800x600, 60 Hz monitor mode while its own clock runs at half the standard pixel rate. Every pixel therefore covers two standard pixel periods. The vertical address advances only on every second scan line, so each image row is shown twice. The frame buffer behind it sees a 400x300 image, and the monitor sees a normal 800x600 signal.

Two counters are built on one counter block. One counts the position within a line and the other counts scan lines. Each counter wraps when a comparator matches its last value, not when it overflows. The line comparator also gives an internal line-end strobe that is active low.

Span comparators decode the counts into sync, display-enable, pixel column, pixel row and a frame-start pulse. All of these outputs are registered, so they change one clock after the counters that drive them. The block has no data stream in or out. Every pin is plain control or status, and there is no handshake.

Top module: `vga_half_timing`

## Requirements
- R1: One scan line lasts exactly H_VIS+H_FP+H_SYNC+H_BP clocks (defaults 400+20+64+44 = 528). Falling edges of `hsync_n_o` are exactly that many clocks apart.
- R2: One frame lasts V_VIS+V_FP+V_SYNC+V_BP lines (defaults 600+1+4+23 = 628). Falling edges of `vsync_n_o` are exactly one line length times that line count apart.
- R3: `hsync_n_o` is active low. Counting horizontal position from 0 at the first visible pixel, it is low exactly at positions H_VIS+H_FP through H_VIS+H_FP+H_SYNC-1, which is H_SYNC clocks per line.
- R4: `vsync_n_o` is active low. It is low for exactly V_SYNC whole lines, starting at line V_VIS+V_FP, where line 0 is the first visible line. It changes only at horizontal position 0.
- R5: `de_o` is 1 exactly when the horizontal position is below H_VIS and the line is below V_VIS, which gives H_VIS clocks on each visible line.
- R6: `col_o` equals the horizontal position while `de_o` is 1, and is 0 while `de_o` is 0.
- R7: `row_o` equals the line number shifted right by ROW_SHIFT (default 1) while `de_o` is 1, and is 0 otherwise. With the default setting, each row value appears on two consecutive scan lines.
- R8: `frame_start_o` is high for one clock per frame. That clock is at horizontal position 0 of line V_VIS+V_FP, the same clock in which `vsync_n_o` falls.
- R9: All outputs are registered. While `rst_n` is low they read hsync 1, vsync 1, de 0, col 0, row 0, frame_start 0. On the first clock edge after reset is released, the outputs show position (0,0): de 1, col 0, row 0.
- R10: Asserting `rst_n` at any point in the frame forces the idle values of R9 at once, and scanning restarts from position (0,0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-rate pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hsync_n_o | output | 1 | Horizontal sync, active low |
| vsync_n_o | output | 1 | Vertical sync, active low |
| de_o | output | 1 | Display enable, high in the visible area |
| col_o | output | COL_W (9) | Pixel column, 0..H_VIS-1 |
| row_o | output | ROW_W (9) | Pixel row, 0..(V_VIS>>ROW_SHIFT)-1 |
| frame_start_o | output | 1 | One-clock pulse at the start of vertical sync |

## Verification
The horizontal timing uses the full default settings. The vertical segments are shortened so that whole frames fit in the run. The bench compares every output on every clock against positions it derives from the requirements.

It targets the one-clock output latency: a design that puts its decode before the register, or adds a second stage, is off by one at every segment edge. It also checks the wrap points. A counter that wraps one clock late or early changes the spacing between sync edges.

Further checks cover row pairing, where an unshifted or wrongly shifted row shows a new value on every line. They also cover the frame pulse, which must sit exactly on the vsync falling edge and occur once per frame. The last check is a reset in the middle of a frame, which must drop the outputs at once and restart from position (0,0).

// File: rtl/vga_half_pkg.sv
package vga_half_pkg;
  // Horizontal segments, in half-rate clocks.
  localparam int unsigned DEF_H_VIS  = 400;
  localparam int unsigned DEF_H_FP   = 20;
  localparam int unsigned DEF_H_SYNC = 64;
  localparam int unsigned DEF_H_BP   = 44;

  // Vertical segments, in scan lines.
  localparam int unsigned DEF_V_VIS  = 600;
  localparam int unsigned DEF_V_FP   = 1;
  localparam int unsigned DEF_V_SYNC = 4;
  localparam int unsigned DEF_V_BP   = 23;

  // Decoded single-bit controls that feed the output register stage.
  typedef struct packed {
    logic hs_n;
    logic vs_n;
    logic de;
    logic fs;
  } sync_bits_t;

  function automatic int unsigned width_for(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/vht_counter.sv
module vht_counter #(
  parameter int unsigned TOTAL = 528,
  parameter int unsigned W     = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv_i,
  output logic [W-1:0] cnt_o,
  output logic         last_o
);
  localparam logic [W-1:0] LAST_C = W'(TOTAL - 1);

  logic [W-1:0] cnt_q;

  // The wrap comes from a compare on the final count, not from overflow.
  assign last_o = (cnt_q == LAST_C);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (adv_i) begin
      if (last_o) cnt_q <= '0;
      else        cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o = cnt_q;

  a_r1_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST_C);
endmodule

// File: rtl/vht_span.sv
module vht_span #(
  parameter int unsigned W     = 10,
  parameter int unsigned START = 0,
  parameter int unsigned LEN   = 1
) (
  input  logic [W-1:0] cnt_i,
  output logic         in_o
);
  localparam int unsigned STOP = START + LEN;

  logic below_stop;
  assign below_stop = ({1'b0, cnt_i} < (W+1)'(STOP));

  generate
    if (START == 0) begin : g_from_zero
      assign in_o = below_stop;
    end else begin : g_offset
      assign in_o = (cnt_i >= W'(START)) && below_stop;
    end
  endgenerate
endmodule

// File: rtl/vht_out_regs.sv
module vht_out_regs
  import vga_half_pkg::*;
#(
  parameter int unsigned COL_W   = 9,
  parameter int unsigned ROW_W   = 9,
  parameter int unsigned ROW_MAX = 299
) (
  input  logic             clk,
  input  logic             rst_n,
  input  sync_bits_t       nxt_i,
  input  logic [COL_W-1:0] col_i,
  input  logic [ROW_W-1:0] row_i,
  output logic             hsync_n_o,
  output logic             vsync_n_o,
  output logic             de_o,
  output logic [COL_W-1:0] col_o,
  output logic [ROW_W-1:0] row_o,
  output logic             frame_start_o
);
  sync_bits_t       bits_q;
  logic [COL_W-1:0] col_q;
  logic [ROW_W-1:0] row_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits_q <= '{hs_n: 1'b1, vs_n: 1'b1, de: 1'b0, fs: 1'b0};
      col_q  <= '0;
      row_q  <= '0;
    end else begin
      bits_q <= nxt_i;
      col_q  <= nxt_i.de ? col_i : '0;
      row_q  <= nxt_i.de ? row_i : '0;
    end
  end

  assign hsync_n_o     = bits_q.hs_n;
  assign vsync_n_o     = bits_q.vs_n;
  assign de_o          = bits_q.de;
  assign col_o         = col_q;
  assign row_o         = row_q;
  assign frame_start_o = bits_q.fs;

  // R5: no sync pulse inside the visible area.
  a_r5_de_outside_sync: assert property (@(posedge clk) disable iff (!rst_n)
    de_o |-> (hsync_n_o && vsync_n_o));

  // R8: the frame pulse sits on the vsync falling edge.
  a_r8_pulse_on_vsync_fall: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start_o |-> (!vsync_n_o && $past(vsync_n_o)));

  // R8: the frame pulse lasts a single clock.
  a_r8_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start_o |=> !frame_start_o);

  // R7: the row output never exceeds the last row.
  a_r7_row_bound: assert property (@(posedge clk) disable iff (!rst_n)
    row_o <= ROW_W'(ROW_MAX));
endmodule

// File: rtl/vga_half_timing.sv
module vga_half_timing
  import vga_half_pkg::*;
#(
  parameter int unsigned H_VIS     = DEF_H_VIS,
  parameter int unsigned H_FP      = DEF_H_FP,
  parameter int unsigned H_SYNC    = DEF_H_SYNC,
  parameter int unsigned H_BP      = DEF_H_BP,
  parameter int unsigned V_VIS     = DEF_V_VIS,
  parameter int unsigned V_FP      = DEF_V_FP,
  parameter int unsigned V_SYNC    = DEF_V_SYNC,
  parameter int unsigned V_BP      = DEF_V_BP,
  parameter int unsigned ROW_SHIFT = 1,
  localparam int unsigned ROWS  = V_VIS >> ROW_SHIFT,
  localparam int unsigned COL_W = width_for(H_VIS),
  localparam int unsigned ROW_W = width_for(ROWS)
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic             hsync_n_o,
  output logic             vsync_n_o,
  output logic             de_o,
  output logic [COL_W-1:0] col_o,
  output logic [ROW_W-1:0] row_o,
  output logic             frame_start_o
);
  localparam int unsigned H_TOT = H_VIS + H_FP + H_SYNC + H_BP;
  localparam int unsigned V_TOT = V_VIS + V_FP + V_SYNC + V_BP;
  localparam int unsigned HW    = width_for(H_TOT);
  localparam int unsigned VW    = width_for(V_TOT);

  logic [HW-1:0] hcnt;
  logic [VW-1:0] vcnt;
  logic          h_last, v_last;
  logic          line_end_n;
  logic          h_vis, h_sync, h_zero;
  logic          v_vis, v_sync, v_fs_line;
  logic [ROW_W-1:0] row_raw;
  sync_bits_t    nxt;

  vht_counter #(.TOTAL(H_TOT), .W(HW)) u_hcnt (
    .clk(clk), .rst_n(rst_n), .adv_i(1'b1), .cnt_o(hcnt), .last_o(h_last));

  vht_counter #(.TOTAL(V_TOT), .W(VW)) u_vcnt (
    .clk(clk), .rst_n(rst_n), .adv_i(h_last), .cnt_o(vcnt), .last_o(v_last));

  // Internal line-end strobe: low for one clock in each line.
  assign line_end_n = !h_last;

  vht_span #(.W(HW), .START(0),             .LEN(H_VIS))  u_hvis  (.cnt_i(hcnt), .in_o(h_vis));
  vht_span #(.W(HW), .START(H_VIS + H_FP),  .LEN(H_SYNC)) u_hsync (.cnt_i(hcnt), .in_o(h_sync));
  vht_span #(.W(HW), .START(0),             .LEN(1))      u_hzero (.cnt_i(hcnt), .in_o(h_zero));
  vht_span #(.W(VW), .START(0),             .LEN(V_VIS))  u_vvis  (.cnt_i(vcnt), .in_o(v_vis));
  vht_span #(.W(VW), .START(V_VIS + V_FP),  .LEN(V_SYNC)) u_vsync (.cnt_i(vcnt), .in_o(v_sync));
  vht_span #(.W(VW), .START(V_VIS + V_FP),  .LEN(1))      u_vfs   (.cnt_i(vcnt), .in_o(v_fs_line));

  generate
    if (ROW_SHIFT == 0) begin : g_row_full
      assign row_raw = ROW_W'(vcnt);
    end else begin : g_row_shifted
      assign row_raw = ROW_W'(vcnt >> ROW_SHIFT);
    end
  endgenerate

  always_comb begin
    nxt.hs_n = !h_sync;
    nxt.vs_n = !v_sync;
    nxt.de   = h_vis && v_vis;
    nxt.fs   = h_zero && v_fs_line;
  end

  vht_out_regs #(.COL_W(COL_W), .ROW_W(ROW_W), .ROW_MAX(ROWS - 1)) u_out (
    .clk(clk), .rst_n(rst_n), .nxt_i(nxt),
    .col_i(COL_W'(hcnt)), .row_i(row_raw),
    .hsync_n_o(hsync_n_o), .vsync_n_o(vsync_n_o), .de_o(de_o),
    .col_o(col_o), .row_o(row_o), .frame_start_o(frame_start_o));

  // R1: the line-end strobe is never low on two clocks in a row.
  a_r1_line_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    !line_end_n |=> line_end_n);

  // R2: the line count moves only across a line wrap.
  a_r2_line_count_holds: assert property (@(posedge clk) disable iff (!rst_n)
    line_end_n |=> $stable(vcnt));

  // R2: the frame wrap happens only together with a line wrap.
  a_r2_frame_wrap_at_line_end: assert property (@(posedge clk) disable iff (!rst_n)
    v_last && !line_end_n |=> (vcnt == '0) && (hcnt == '0));
endmodule

// File: tb/vga_half_timing_tb_top.sv
module vga_half_timing_tb_top;
  localparam int H_VIS = 400, H_FP = 20, H_SYNC = 64, H_BP = 44;
  localparam int V_VIS = 8, V_FP = 1, V_SYNC = 2, V_BP = 3;
  localparam int H_TOT = H_VIS + H_FP + H_SYNC + H_BP;
  localparam int V_TOT = V_VIS + V_FP + V_SYNC + V_BP;
  localparam int FRAME = H_TOT * V_TOT;
  localparam int COL_W = 9;
  localparam int ROW_W = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hsync_n, vsync_n, de, fs;
  logic [COL_W-1:0] col;
  logic [ROW_W-1:0] row;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  int mh = 0, mv = 0, s_h = 0, s_v = 0;
  int cyc = 0, last_hf = -1, last_vf = -1, fs_cnt = 0, vs_low = 0, hs_low = 0, de_cnt = 0;
  logic prev_hs = 1'b1, prev_vs = 1'b1;

  always #2 clk = ~clk;

  vga_half_timing #(
    .H_VIS(H_VIS), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
    .V_VIS(V_VIS), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP), .ROW_SHIFT(1)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .hsync_n_o(hsync_n), .vsync_n_o(vsync_n),
    .de_o(de), .col_o(col), .row_o(row), .frame_start_o(fs));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (pos h=%0d v=%0d)", req, act, exp, s_h, s_v);
    end
  endtask

  task automatic clear_meas();
    cyc = 0; last_hf = -1; last_vf = -1; fs_cnt = 0; vs_low = 0; hs_low = 0; de_cnt = 0;
    prev_hs = 1'b1; prev_vs = 1'b1;
  endtask

  // One clock: sample after the edge, compare with the model position, then advance.
  task automatic step();
    bit e_de;
    @(posedge clk);
    #1;
    s_h = mh; s_v = mv;
    e_de = (mh < H_VIS) && (mv < V_VIS);
    chk("R3 hsync", int'(hsync_n), (mh >= H_VIS + H_FP && mh < H_VIS + H_FP + H_SYNC) ? 0 : 1);
    chk("R4 vsync", int'(vsync_n), (mv >= V_VIS + V_FP && mv < V_VIS + V_FP + V_SYNC) ? 0 : 1);
    chk("R5 de", int'(de), int'(e_de));
    chk("R6 col", int'(col), e_de ? mh : 0);
    chk("R7 row", int'(row), e_de ? (mv / 2) : 0);
    chk("R8 frame_start", int'(fs), (mh == 0 && mv == V_VIS + V_FP) ? 1 : 0);
    if (prev_hs && !hsync_n) begin
      if (last_hf >= 0) chk("R1 hsync period", cyc - last_hf, H_TOT);
      last_hf = cyc;
    end
    if (prev_vs && !vsync_n) begin
      if (last_vf >= 0) chk("R2 vsync period", cyc - last_vf, FRAME);
      last_vf = cyc;
    end
    if (fs) fs_cnt++;
    if (!vsync_n) vs_low++;
    if (!hsync_n) hs_low++;
    if (de) de_cnt++;
    prev_hs = hsync_n; prev_vs = vsync_n;
    cyc++;
    mh++;
    if (mh == H_TOT) begin
      mh = 0;
      mv = (mv == V_TOT - 1) ? 0 : mv + 1;
    end
  endtask

  task automatic chk_idle(input string req);
    chk({req, " hsync idle"}, int'(hsync_n), 1);
    chk({req, " vsync idle"}, int'(vsync_n), 1);
    chk({req, " de idle"}, int'(de), 0);
    chk({req, " col idle"}, int'(col), 0);
    chk({req, " row idle"}, int'(row), 0);
    chk({req, " frame_start idle"}, int'(fs), 0);
  endtask

  task automatic test_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk_idle("R9");
    @(negedge clk);
    rst_n = 1'b1;
    mh = 0; mv = 0;
    clear_meas();
    step();
    chk("R9 first de", int'(de), 1);
    chk("R9 first col", int'(col), 0);
  endtask

  task automatic test_hline();
    for (int i = 1; i < H_TOT; i++) step();
    chk("R3 hsync low count", hs_low, H_SYNC);
    chk("R5 de count per line", de_cnt, H_VIS);
  endtask

  task automatic test_frames();
    clear_meas();
    for (int i = 0; i < 2 * FRAME; i++) step();
    chk("R8 pulses in two frames", fs_cnt, 2);
    chk("R4 vsync low clocks", vs_low, 2 * V_SYNC * H_TOT);
    chk("R5 de clocks in two frames", de_cnt, 2 * H_VIS * V_VIS);
  endtask

  task automatic test_row_pairs();
    do step(); while (!(s_h == 5 && s_v == 4));
    chk("R7 row on line 4", int'(row), 2);
    do step(); while (!(s_h == 5 && s_v == 5));
    chk("R7 row repeated on line 5", int'(row), 2);
    do step(); while (!(s_h == 5 && s_v == 6));
    chk("R7 row advances on line 6", int'(row), 3);
  endtask

  task automatic test_midframe_reset();
    do step(); while (!(s_h == 300 && s_v == 3));
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk_idle("R10");
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    mh = 0; mv = 0;
    clear_meas();
    step();
    chk("R10 restart de", int'(de), 1);
    chk("R10 restart col", int'(col), 0);
    chk("R10 restart row", int'(row), 0);
    for (int i = 1; i < FRAME + H_TOT; i++) step();
    chk("R10 one pulse after restart", fs_cnt, 1);
  endtask

  initial begin
    test_reset();
    test_hline();
    test_frames();
    test_row_pairs();
    test_midframe_reset();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (80000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule